// File: doc/BRIEF.md
# Multicycle Sequencing Controller

This block is the step sequencer for a processor that runs each instruction over several clock cycles on one shared memory, one ALU and a handful of holding registers (instruction, memory data, two operand registers and an ALU result register). It watches the 6-bit opcode field of the latched instruction and, from a 4-bit state register, drives every select, enable and mode line the datapath needs in the current step. All control outputs are a function of the current step alone.

An instruction always begins with a fetch step and a decode step. The decode step dispatches by opcode to one of four short paths: memory reference, register-to-register arithmetic, conditional branch, or jump. Loads take five cycles, stores and arithmetic four, branches and jumps three. The block also combines its unconditional and conditional PC write lines with the ALU zero flag into one PC load enable.

Top module: `mc_seq_ctl`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge puts the controller into the fetch step. In the fetch step `mem_rd_o`, `instr_ld_o` and `pc_wr_o` are 1, `alu_b_sel_o` is 01, and `mem_addr_sel_o`, `alu_a_sel_o`, `alu_mode_o` and `pc_next_sel_o` are 0; every other control output is 0.
- R2: The step after fetch is always decode, where `alu_b_sel_o` is 11, `alu_a_sel_o` is 0, `alu_mode_o` is 00 and all other control outputs are 0.
- R3: From decode, opcode 100011 (load) or 101011 (store) goes to the address step, 000000 goes to the arithmetic execute step, 000100 goes to the branch step, 000010 goes to the jump step, and any other opcode returns to fetch.
- R4: The address step drives `alu_a_sel_o`=1, `alu_b_sel_o`=10, `alu_mode_o`=00 with all else 0; it is followed by the load read step for opcode 101011 absent, i.e. the store step when the opcode is 101011 and the load read step otherwise.
- R5: The load read step drives `mem_rd_o`=1 and `mem_addr_sel_o`=1; the next step drives `rf_wr_o`=1, `wb_from_mem_o`=1, `dst_rd_sel_o`=0, then fetch follows. A load occupies five cycles.
- R6: The store step drives `mem_wr_o`=1 and `mem_addr_sel_o`=1, then fetch follows. A store occupies four cycles.
- R7: The execute step drives `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_mode_o`=10; the next step drives `rf_wr_o`=1, `dst_rd_sel_o`=1, `wb_from_mem_o`=0, then fetch follows. An arithmetic instruction occupies four cycles.
- R8: The branch step drives `alu_a_sel_o`=1, `alu_b_sel_o`=00, `alu_mode_o`=01, `pc_next_sel_o`=01 and `pc_wr_if_zero_o`=1, then fetch follows (three cycles).
- R9: The jump step drives `pc_wr_o`=1 and `pc_next_sel_o`=10, then fetch follows (three cycles).
- R10: `pc_load_o` is 1 exactly when `pc_wr_o` is 1, or when `pc_wr_if_zero_o` and `alu_zero_i` are both 1.
- R11: Opcode changes outside the decode and address steps have no effect on the step sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the latched instruction |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| mem_addr_sel_o | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| instr_ld_o | output | 1 | Load instruction register from memory |
| dst_rd_sel_o | output | 1 | Register destination from bits 15:11 (1) or 20:16 (0) |
| rf_wr_o | output | 1 | Register file write enable |
| wb_from_mem_o | output | 1 | Write-back data from memory data register (1) or ALU result register (0) |
| alu_a_sel_o | output | 1 | First ALU operand from operand register (1) or PC (0) |
| alu_b_sel_o | output | 2 | Second operand: 00 register, 01 constant four, 10 extended immediate, 11 extended immediate times four |
| alu_mode_o | output | 2 | 00 add, 01 subtract, 10 function field decides |
| pc_next_sel_o | output | 2 | PC source: 00 ALU output, 01 ALU result register, 10 jump target |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_if_zero_o | output | 1 | PC write when zero flag is set |
| pc_load_o | output | 1 | Combined PC load enable |

## Verification
Each of the five recognised opcodes is run through a full instruction, and each step's whole output vector is compared, so a wrong dispatch or a misplaced control bit in any step shows as a mismatch at a known cycle. Branches are run with the zero flag both set and clear, and loads and arithmetic with the flag set, which separates a correct conditional PC load from one that leaks into other steps. Two unassigned opcodes confirm the early return to fetch, and opcode changes injected mid-instruction, plus a reset in the middle of a load, show that the sequence depends only on decode-time opcode and reset.

// File: rtl/mc_ctl_pkg.sv
// Shared types and constants for the multicycle sequencing controller.
// Assumes a 6-bit opcode field and a 4-bit binary step register.
package mc_ctl_pkg;

    localparam int OPC_W     = 6;
    localparam int STATE_W   = 4;
    localparam int NUM_KNOWN = 5;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_ARITH = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_EXEC   = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } step_t;

    typedef enum logic [2:0] {
        CLS_LOAD,
        CLS_STORE,
        CLS_ARITH,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_NONE
    } opclass_t;

    localparam logic [OPC_W-1:0] KNOWN_OPC [NUM_KNOWN] =
        '{OPC_LOAD, OPC_STORE, OPC_ARITH, OPC_BEQ, OPC_JUMP};
    localparam opclass_t KNOWN_CLS [NUM_KNOWN] =
        '{CLS_LOAD, CLS_STORE, CLS_ARITH, CLS_BRANCH, CLS_JUMP};

    typedef struct packed {
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_ld;
        logic       dst_rd;
        logic       rf_wr;
        logic       wb_mem;
        logic       a_sel;
        logic [1:0] b_sel;
        logic [1:0] mode;
        logic [1:0] pc_sel;
        logic       pc_wr;
        logic       pc_wr_z;
    } ctl_t;

endpackage

// File: rtl/mc_op_classify.sv
// Maps an opcode onto an instruction class.
// Assumes opcodes in KNOWN_OPC are distinct; unmatched opcodes give CLS_NONE.
module mc_op_classify
    import mc_ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output opclass_t         cls_o
);

    logic [NUM_KNOWN-1:0] hit;

    // One comparator per recognised opcode.
    for (genvar g = 0; g < NUM_KNOWN; g++) begin : g_match
        assign hit[g] = (opcode_i == KNOWN_OPC[g]);
    end

    // Lowest index match wins; none means unrecognised.
    always_comb begin
        cls_o = CLS_NONE;
        for (int k = NUM_KNOWN - 1; k >= 0; k--) begin
            if (hit[k]) cls_o = KNOWN_CLS[k];
        end
    end

endmodule

// File: rtl/mc_step_next.sv
// Next-step function of the sequencer.
// Assumes the class input reflects the opcode of the instruction in flight.
module mc_step_next
    import mc_ctl_pkg::*;
(
    input  step_t    cur_i,
    input  opclass_t cls_i,
    output step_t    nxt_o
);

    // Chooses the following step from the current step and the class.
    always_comb begin
        case (cur_i)
            ST_FETCH:  nxt_o = ST_DECODE;
            ST_DECODE: begin
                case (cls_i)
                    CLS_LOAD, CLS_STORE: nxt_o = ST_ADDR;
                    CLS_ARITH:           nxt_o = ST_EXEC;
                    CLS_BRANCH:          nxt_o = ST_BRANCH;
                    CLS_JUMP:            nxt_o = ST_JUMP;
                    default:             nxt_o = ST_FETCH;
                endcase
            end
            ST_ADDR:   nxt_o = (cls_i == CLS_STORE) ? ST_STWR : ST_LDRD;
            ST_LDRD:   nxt_o = ST_LDWB;
            ST_EXEC:   nxt_o = ST_ALUWB;
            default:   nxt_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctl_decode.sv
// Moore output decoder: control vector for each step.
// Assumes any unnamed field is inactive (0) in that step.
module mc_ctl_decode
    import mc_ctl_pkg::*;
(
    input  step_t cur_i,
    output ctl_t  ctl_o
);

    // Builds the control vector of the current step from an all-zero base.
    always_comb begin
        ctl_o = '0;
        case (cur_i)
            ST_FETCH: begin
                ctl_o.mem_rd   = 1'b1;
                ctl_o.instr_ld = 1'b1;
                ctl_o.b_sel    = 2'b01;
                ctl_o.pc_wr    = 1'b1;
            end
            ST_DECODE: begin
                ctl_o.b_sel = 2'b11;
            end
            ST_ADDR: begin
                ctl_o.a_sel = 1'b1;
                ctl_o.b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl_o.mem_rd   = 1'b1;
                ctl_o.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl_o.rf_wr  = 1'b1;
                ctl_o.wb_mem = 1'b1;
            end
            ST_STWR: begin
                ctl_o.mem_wr   = 1'b1;
                ctl_o.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl_o.a_sel = 1'b1;
                ctl_o.mode  = 2'b10;
            end
            ST_ALUWB: begin
                ctl_o.rf_wr  = 1'b1;
                ctl_o.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl_o.a_sel   = 1'b1;
                ctl_o.mode    = 2'b01;
                ctl_o.pc_sel  = 2'b01;
                ctl_o.pc_wr_z = 1'b1;
            end
            ST_JUMP: begin
                ctl_o.pc_wr  = 1'b1;
                ctl_o.pc_sel = 2'b10;
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/mc_seq_ctl.sv
// Top of the multicycle sequencing controller.
// Holds the step register, decodes the opcode, drives the Moore control
// outputs and forms the combined PC load enable. Assumes opcode_i is stable
// from the decode step until the instruction completes.
module mc_seq_ctl
    import mc_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             alu_zero_i,
    output logic             mem_addr_sel_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             instr_ld_o,
    output logic             dst_rd_sel_o,
    output logic             rf_wr_o,
    output logic             wb_from_mem_o,
    output logic             alu_a_sel_o,
    output logic [1:0]       alu_b_sel_o,
    output logic [1:0]       alu_mode_o,
    output logic [1:0]       pc_next_sel_o,
    output logic             pc_wr_o,
    output logic             pc_wr_if_zero_o,
    output logic             pc_load_o
);

    step_t    cur_q;
    step_t    nxt;
    opclass_t cls;
    ctl_t     ctl;

    mc_op_classify u_cls (
        .opcode_i (opcode_i),
        .cls_o    (cls)
    );

    mc_step_next u_nxt (
        .cur_i (cur_q),
        .cls_i (cls),
        .nxt_o (nxt)
    );

    mc_ctl_decode u_dec (
        .cur_i (cur_q),
        .ctl_o (ctl)
    );

    // Step register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_FETCH;
        else        cur_q <= nxt;
    end

    // Fans the control vector out to the ports.
    always_comb begin
        mem_addr_sel_o  = ctl.addr_sel;
        mem_rd_o        = ctl.mem_rd;
        mem_wr_o        = ctl.mem_wr;
        instr_ld_o      = ctl.instr_ld;
        dst_rd_sel_o    = ctl.dst_rd;
        rf_wr_o         = ctl.rf_wr;
        wb_from_mem_o   = ctl.wb_mem;
        alu_a_sel_o     = ctl.a_sel;
        alu_b_sel_o     = ctl.b_sel;
        alu_mode_o      = ctl.mode;
        pc_next_sel_o   = ctl.pc_sel;
        pc_wr_o         = ctl.pc_wr;
        pc_wr_if_zero_o = ctl.pc_wr_z;
    end

    // Combines unconditional and zero-gated PC writes.
    always_comb begin
        pc_load_o = ctl.pc_wr | (ctl.pc_wr_z & alu_zero_i);
    end

endmodule

// File: rtl/mc_seq_ctl_chk.sv
// Property checker for mc_seq_ctl, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module mc_seq_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] opcode_i,
    input logic       alu_zero_i,
    input logic       mem_addr_sel_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       instr_ld_o,
    input logic       dst_rd_sel_o,
    input logic       rf_wr_o,
    input logic       wb_from_mem_o,
    input logic       alu_a_sel_o,
    input logic [1:0] alu_b_sel_o,
    input logic [1:0] alu_mode_o,
    input logic [1:0] pc_next_sel_o,
    input logic       pc_wr_o,
    input logic       pc_wr_if_zero_o,
    input logic       pc_load_o
);

    logic known_opc;
    assign known_opc = (opcode_i == 6'b100011) || (opcode_i == 6'b101011) ||
                       (opcode_i == 6'b000000) || (opcode_i == 6'b000100) ||
                       (opcode_i == 6'b000010);

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ld_o |=> (alu_b_sel_o == 2'b11) && !alu_a_sel_o);

    assert_arith_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_b_sel_o == 2'b11) && (opcode_i == 6'b000000) |=> (alu_mode_o == 2'b10));

    assert_unknown_refetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_b_sel_o == 2'b11) && !known_opc |=> instr_ld_o);

    assert_store_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> mem_addr_sel_o && !mem_rd_o && !rf_wr_o);

    assert_store_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> instr_ld_o);

    assert_writeback_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_o |=> instr_ld_o);

    assert_cond_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o && !pc_wr_o |-> alu_zero_i && pc_wr_if_zero_o);

    assert_taken_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_if_zero_o && alu_zero_i |-> pc_load_o);

    assert_mem_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, rf_wr_o}));

endmodule

bind mc_seq_ctl mc_seq_ctl_chk chk_i (.*);

// File: tb/mc_seq_ctl_tb.sv
`timescale 1ns/1ps
module mc_seq_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'b000000;
    logic       zero = 1'b0;
    logic       mem_addr_sel, mem_rd, mem_wr, instr_ld, dst_rd_sel, rf_wr;
    logic       wb_from_mem, alu_a_sel, pc_wr, pc_wr_if_zero, pc_load;
    logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    mc_seq_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .alu_zero_i(zero),
        .mem_addr_sel_o(mem_addr_sel), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .instr_ld_o(instr_ld), .dst_rd_sel_o(dst_rd_sel), .rf_wr_o(rf_wr),
        .wb_from_mem_o(wb_from_mem), .alu_a_sel_o(alu_a_sel),
        .alu_b_sel_o(alu_b_sel), .alu_mode_o(alu_mode),
        .pc_next_sel_o(pc_next_sel), .pc_wr_o(pc_wr),
        .pc_wr_if_zero_o(pc_wr_if_zero), .pc_load_o(pc_load)
    );

    // {opcode, zero, length, step list (step k in bits 4k+3:4k)}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {6'b100011, 1'b0, 3'd5, 20'h43210},
        {6'b101011, 1'b0, 3'd4, 20'h05210},
        {6'b000000, 1'b1, 3'd4, 20'h07610},
        {6'b000100, 1'b1, 3'd3, 20'h00810},
        {6'b000100, 1'b0, 3'd3, 20'h00810},
        {6'b000010, 1'b1, 3'd3, 20'h00910},
        {6'b111111, 1'b0, 3'd2, 20'h00010},
        {6'b000101, 1'b1, 3'd2, 20'h00010},
        {6'b000000, 1'b0, 3'd4, 20'h07610},
        {6'b100011, 1'b1, 3'd5, 20'h43210}
    };

    // Expected port vector per step, written from the requirements.
    function automatic logic [16:0] exp_vec(input logic [3:0] st, input logic z);
        logic as, rd, wr, il, dr, rw, wm, a, pw, pz;
        logic [1:0] b, m, ps;
        {as, rd, wr, il, dr, rw, wm, a, pw, pz} = '0;
        b = 2'b00; m = 2'b00; ps = 2'b00;
        case (st)
            4'd0: begin rd = 1; il = 1; b = 2'b01; pw = 1; end
            4'd1: b = 2'b11;
            4'd2: begin a = 1; b = 2'b10; end
            4'd3: begin rd = 1; as = 1; end
            4'd4: begin rw = 1; wm = 1; end
            4'd5: begin wr = 1; as = 1; end
            4'd6: begin a = 1; m = 2'b10; end
            4'd7: begin rw = 1; dr = 1; end
            4'd8: begin a = 1; m = 2'b01; ps = 2'b01; pz = 1; end
            4'd9: begin pw = 1; ps = 2'b10; end
            default: ;
        endcase
        return {as, rd, wr, il, dr, rw, wm, a, b, m, ps, pw, pz, pw | (pz & z)};
    endfunction

    function automatic logic [16:0] act_vec();
        return {mem_addr_sel, mem_rd, mem_wr, instr_ld, dst_rd_sel, rf_wr,
                wb_from_mem, alu_a_sel, alu_b_sel, alu_mode, pc_next_sel,
                pc_wr, pc_wr_if_zero, pc_load};
    endfunction

    function automatic string req_of(input logic [3:0] st);
        case (st)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8: return "R8/R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] st);
        logic [16:0] e;
        e = exp_vec(st, zero);
        n_cmp++;
        if (act_vec() !== e) begin
            n_bad++;
            $display("FAIL %s step %0d: actual %h expected %h", req, st, act_vec(), e);
        end
    endtask

    // Compare at mid-cycle, then move to the next falling edge.
    task automatic step_chk(input string req, input logic [3:0] st);
        #1;
        check(req, st);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R1: outputs during reset show the fetch step.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", 4'd0);
        rst_n = 1'b1;

        // Table walk; the step after each instruction is the next entry's fetch (R3).
        for (int i = 0; i < NV; i++) begin
            opcode = VEC[i][29:24];
            zero   = VEC[i][23];
            for (int k = 0; k < int'(VEC[i][22:20]); k++) begin
                logic [3:0] st;
                st = VEC[i][4*k +: 4];
                step_chk((k == 1) ? "R3" : req_of(st), st);
            end
        end

        // R11: opcode changed after the load dispatch has no effect.
        opcode = 6'b100011; zero = 1'b0;
        step_chk("R1", 4'd0);
        step_chk("R2", 4'd1);
        step_chk("R4", 4'd2);
        opcode = 6'b101011;
        step_chk("R11", 4'd3);
        opcode = 6'b000010;
        step_chk("R11", 4'd4);

        // R11: opcode changed during arithmetic execute has no effect.
        opcode = 6'b000000;
        step_chk("R1", 4'd0);
        step_chk("R2", 4'd1);
        opcode = 6'b000100;
        step_chk("R11", 4'd6);
        step_chk("R11", 4'd7);

        // R10: zero flag outside the branch step leaves pc_load at pc_wr.
        opcode = 6'b000010; zero = 1'b1;
        step_chk("R10", 4'd0);
        step_chk("R10", 4'd1);
        step_chk("R9", 4'd9);

        // R1: reset in the middle of a load returns to fetch.
        opcode = 6'b100011; zero = 1'b0;
        step_chk("R1", 4'd0);
        step_chk("R2", 4'd1);
        step_chk("R4", 4'd2);
        #1; check("R5", 4'd3);
        rst_n = 1'b0;
        @(negedge clk);
        step_chk("R1", 4'd0);
        rst_n = 1'b1;
        #1; check("R1", 4'd0);
        @(negedge clk);
        step_chk("R2", 4'd1);
        step_chk("R4", 4'd2);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule